// File: doc/BRIEF.md
# Duplex Output Checkback Supervisor

This block watches over a redundant pair of interlocking controllers, side A and side B. Only one side is in control at a time. Each side presents a vector of commanded relay outputs and a matching vector of checkback inputs. The checkbacks are read through back contacts, so a correctly operated relay shows its checkback low while its output is on and high while its output is off. For the side in control, the supervisor compares every output bit with its checkback. After any change of command it first waits a programmable number of cycles, so that relay travel time is not mistaken for a fault.

A disagreement on any bit halts the side in control. So does a fault flag from either of that side's two CPUs. The halted side loses its health output, control moves to the standby side, and a sticky switchover alarm is raised. A halted side stays locked out until reset, and control never passes to a side that is already halted. A fault flag on the standby side locks that side out as well. Once both sides are halted, no side is in control, both health outputs stay low, and a total-failure alarm is raised.

Top module: `duplex_checkback_sup`

## Requirements
- R1: After reset, side A is in control, healthA is high, healthB is low, and both alarms are low.
- R2: At no time are both sides in control, or both health outputs high.
- R3: For the side in control, a checkback bit that is the inverse of its command bit is correct. Every command pattern, held with inverted checkbacks, leaves control unchanged.
- R4: With the settle window over, a single checkback bit equal to its command bit halts the side in control. On the next clock edge control passes to the other side if that side is not halted.
- R5: A command change seen at a clock edge restarts a window of SETTLE_CYCLES further edges. Disagreements at that edge and within the window are ignored. The first compared edge is SETTLE_CYCLES+1 edges after the change. A switchover also restarts the window.
- R6: Either CPU fault flag of the side in control halts that side and causes a switchover at the next edge.
- R7: A switchover caused by a failure sets switchAlarm. switchAlarm then stays high until reset.
- R8: A side's health output is high only while that side is in control and neither of its CPU fault flags is raised.
- R9: A halted side stays out of control until reset, even after its fault clears. A CPU fault on the standby side halts it, and no switchover is later made to it.
- R10: When both sides are halted, totalFail is high, no side is in control, and both health outputs are low.
- R11: Commands, checkbacks and mismatches of the standby side have no effect on control or alarms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdA | input | NUM_OUT | Side A commanded outputs, 1 = energise |
| cmdB | input | NUM_OUT | Side B commanded outputs, 1 = energise |
| chkA | input | NUM_OUT | Side A checkback inputs, back-contact sense |
| chkB | input | NUM_OUT | Side B checkback inputs, back-contact sense |
| cpuFaultA | input | NUM_CPU | Side A per-CPU fault flags |
| cpuFaultB | input | NUM_CPU | Side B per-CPU fault flags |
| sideAOn | output | 1 | Side A is in control |
| sideBOn | output | 1 | Side B is in control |
| healthA | output | 1 | Side A health output |
| healthB | output | 1 | Side B health output |
| switchAlarm | output | 1 | Sticky alarm for a failure switchover |
| totalFail | output | 1 | Both sides halted |

## Verification
The hardest situation to reach is a mismatch on side B after its own settle window. Side B only compares once it is in control, and that takes a deliberate failure of side A. The stimulus faults side A, waits out the restarted window, and then flips each checkback bit of side B in turn. The settle boundary is swept by holding a stale checkback for every delay from zero to past the window. The bench predicts a fault exactly when the stale value reaches edge SETTLE_CYCLES+1.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    SIDE_A    = 2'd0,
    SIDE_B    = 2'd1,
    SIDE_NONE = 2'd2
  } sideState_t;

  typedef struct packed {
    logic selB;     // compare side B vectors
    logic restart;  // restart the settle window
  } dpStrobe_t;
endpackage

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int NUM_OUT       = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] cmdA,
  input  logic [NUM_OUT-1:0] cmdB,
  input  logic [NUM_OUT-1:0] chkA,
  input  logic [NUM_OUT-1:0] chkB,
  input  dpStrobe_t          strobe,
  output logic               mismatchHit
);
  localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [NUM_OUT-1:0] cmdAct, chkAct, cmdPrev, bitBad;
  logic [CNT_W-1:0]   settleCnt;
  logic               cmdChanged, cmpEnable;

  assign cmdAct = strobe.selB ? cmdB : cmdA;
  assign chkAct = strobe.selB ? chkB : chkA;

  // back-contact sense: a good bit has checkback opposite to command
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    assign bitBad[i] = ~(cmdAct[i] ^ chkAct[i]);
  end

  assign cmdChanged  = (cmdAct != cmdPrev);
  assign cmpEnable   = (settleCnt == '0) && !cmdChanged && !strobe.restart;
  assign mismatchHit = cmpEnable && (|bitBad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdPrev   <= '0;
      settleCnt <= CNT_LOAD;
    end else begin
      cmdPrev <= cmdAct;
      if (cmdChanged || strobe.restart) settleCnt <= CNT_LOAD;
      else if (settleCnt != '0)         settleCnt <= settleCnt - 1'b1;
    end
  end

  // R5: the edge after a command change is never compared
  p_settle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (SETTLE_CYCLES > 0 && cmdChanged) |=> !mismatchHit);
endmodule

// File: rtl/dcs_control.sv
module dcs_control
  import dcs_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mismatchHit,
  input  logic [NUM_CPU-1:0] cpuFaultA,
  input  logic [NUM_CPU-1:0] cpuFaultB,
  output dpStrobe_t          strobe,
  output logic               sideAOn,
  output logic               sideBOn,
  output logic               healthA,
  output logic               healthB,
  output logic               switchAlarm,
  output logic               totalFail
);
  sideState_t state, stateNext;
  logic haltA, haltB, failA, failB, newHaltA, newHaltB, activeFails;

  assign failA = (|cpuFaultA) || (state == SIDE_A && mismatchHit);
  assign failB = (|cpuFaultB) || (state == SIDE_B && mismatchHit);
  assign newHaltA = haltA || failA;
  assign newHaltB = haltB || failB;
  assign activeFails = (state == SIDE_A && failA) || (state == SIDE_B && failB);

  always_comb begin
    stateNext = state;
    unique case (state)
      SIDE_A:  if (newHaltA) stateNext = newHaltB ? SIDE_NONE : SIDE_B;
      SIDE_B:  if (newHaltB) stateNext = newHaltA ? SIDE_NONE : SIDE_A;
      default: stateNext = SIDE_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SIDE_A;
      haltA       <= 1'b0;
      haltB       <= 1'b0;
      switchAlarm <= 1'b0;
      totalFail   <= 1'b0;
    end else begin
      state       <= stateNext;
      haltA       <= newHaltA;
      haltB       <= newHaltB;
      switchAlarm <= switchAlarm || activeFails;
      totalFail   <= newHaltA && newHaltB;
    end
  end

  assign strobe.selB    = (state == SIDE_B);
  assign strobe.restart = 1'b0;
  assign sideAOn = (state == SIDE_A);
  assign sideBOn = (state == SIDE_B);
  assign healthA = sideAOn && !haltA && !(|cpuFaultA);
  assign healthB = sideBOn && !haltB && !(|cpuFaultB);

  p_single_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(healthA && healthB) && !(sideAOn && sideBOn));
  p_switch_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sideAOn && mismatchHit && !haltB && !(|cpuFaultB)) |=> sideBOn);
  p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    haltA |=> !sideAOn);
  p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    switchAlarm |=> switchAlarm);
  p_total_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    totalFail |-> (!healthA && !healthB && !sideAOn && !sideBOn));
endmodule

// File: rtl/duplex_checkback_sup.sv
module duplex_checkback_sup
  import dcs_pkg::*;
#(
  parameter int NUM_OUT       = 8,
  parameter int NUM_CPU       = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] cmdA,
  input  logic [NUM_OUT-1:0] cmdB,
  input  logic [NUM_OUT-1:0] chkA,
  input  logic [NUM_OUT-1:0] chkB,
  input  logic [NUM_CPU-1:0] cpuFaultA,
  input  logic [NUM_CPU-1:0] cpuFaultB,
  output logic               sideAOn,
  output logic               sideBOn,
  output logic               healthA,
  output logic               healthB,
  output logic               switchAlarm,
  output logic               totalFail
);
  dpStrobe_t ctlStrobe, dpStrobe;
  logic      mismatchHit, selBPrev;

  // a change of selected side restarts the settle window
  always_ff @(posedge clk) begin
    if (!rst_n) selBPrev <= 1'b0;
    else        selBPrev <= ctlStrobe.selB;
  end
  assign dpStrobe.selB    = ctlStrobe.selB;
  assign dpStrobe.restart = ctlStrobe.restart || (ctlStrobe.selB != selBPrev);

  dcs_datapath #(.NUM_OUT(NUM_OUT), .SETTLE_CYCLES(SETTLE_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .cmdA(cmdA), .cmdB(cmdB), .chkA(chkA), .chkB(chkB),
    .strobe(dpStrobe), .mismatchHit(mismatchHit)
  );

  dcs_control #(.NUM_CPU(NUM_CPU)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mismatchHit(mismatchHit),
    .cpuFaultA(cpuFaultA), .cpuFaultB(cpuFaultB), .strobe(ctlStrobe),
    .sideAOn(sideAOn), .sideBOn(sideBOn), .healthA(healthA), .healthB(healthB),
    .switchAlarm(switchAlarm), .totalFail(totalFail)
  );
endmodule

// File: tb/duplex_checkback_sup_bench.sv
module duplex_checkback_sup_bench;
  localparam int N = 4;
  localparam int C = 2;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] cmdA, cmdB, chkA, chkB;
  logic [C-1:0] cpuFaultA, cpuFaultB;
  logic sideAOn, sideBOn, healthA, healthB, switchAlarm, totalFail;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  duplex_checkback_sup #(.NUM_OUT(N), .NUM_CPU(C), .SETTLE_CYCLES(S)) u_duplex_checkback_sup (
    .clk(clk), .rst_n(rst_n), .cmdA(cmdA), .cmdB(cmdB), .chkA(chkA), .chkB(chkB),
    .cpuFaultA(cpuFaultA), .cpuFaultB(cpuFaultB), .sideAOn(sideAOn), .sideBOn(sideBOn),
    .healthA(healthA), .healthB(healthB), .switchAlarm(switchAlarm), .totalFail(totalFail));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // packs {sideAOn, sideBOn, healthA, healthB, switchAlarm, totalFail}
  function automatic int outs();
    return {sideAOn, sideBOn, healthA, healthB, switchAlarm, totalFail};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; cmdA = '0; cmdB = '0; chkA = '1; chkB = '1;
    cpuFaultA = '0; cpuFaultB = '0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    doReset();
    check("R1 reset outputs", outs(), 6'b101000);
    step(S + 2);
    check("R1 idle after window", outs(), 6'b101000);

    // R3: every command pattern with inverted checkbacks
    for (int v = 0; v < (1 << N); v++) begin
      cmdA = N'(v); chkA = ~N'(v);
      step(S + 3);
      check("R3 inverted checkback accepted", outs(), 6'b101000);
    end

    // R11: standby mismatches ignored
    cmdB = 4'b1010; chkB = 4'b1010;
    step(S + 3);
    check("R11 standby mismatch ignored", outs(), 6'b101000);

    // R4/R7: single-bit mismatch on side A, each bit
    for (int b = 0; b < N; b++) begin
      doReset();
      step(S + 2);
      chkA[b] = 1'b0;
      step(1);
      check("R4 switch to B after A mismatch", outs(), 6'b010110);
      check("R7 alarm raised", switchAlarm, 1);
    end

    // R4 on side B after its own window
    for (int b = 0; b < N; b++) begin
      doReset();
      cpuFaultA = 2'b01;
      step(1);
      cpuFaultA = '0;
      check("R6 CPU fault switches to B", outs(), 6'b010110);
      step(S + 3);
      check("R9 A stays out after fault clears", outs(), 6'b010110);
      cmdB = 4'b0110; chkB = 4'b1001;
      step(S + 3);
      check("R3 side B healthy", outs(), 6'b010110);
      chkB[b] = ~chkB[b];
      step(1);
      check("R10 B mismatch with A halted", outs(), 6'b000011);
    end

    // R5: settle window sweep
    for (int d = 0; d <= S + 3; d++) begin
      doReset();
      step(S + 2);
      cmdA = 4'b1111; // chkA stays all-ones: every bit disagrees
      step(d);
      chkA = 4'b0000;
      step(S + 3);
      check($sformatf("R5 settle delay %0d", d), sideBOn, (d >= S + 2) ? 1 : 0);
    end

    // R5: switchover restarts the window on side B
    doReset();
    cmdB = 4'b0001; chkB = 4'b0001;
    cpuFaultA = 2'b10;
    step(1);
    cpuFaultA = '0;
    step(S);
    chkB = 4'b1110;
    step(2);
    check("R5 window after switchover", outs(), 6'b010110);

    // R8: health drops at once with a fault flag
    doReset();
    cpuFaultA = 2'b10;
    #1;
    check("R8 health low on CPU fault", healthA, 0);
    step(1);
    cpuFaultA = '0;
    check("R6 second CPU fault switches", outs(), 6'b010110);

    // R9: standby fault, then active fault gives total failure
    doReset();
    cpuFaultB = 2'b01;
    step(1);
    cpuFaultB = '0;
    check("R9 standby fault keeps A", outs(), 6'b101000);
    step(2);
    cpuFaultA = 2'b01;
    step(1);
    cpuFaultA = '0;
    check("R10 total failure, no switch to halted B", outs(), 6'b000011);
    step(3);
    check("R10 stays dark", outs(), 6'b000011);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule